// File: doc/BRIEF.md
# Single-Cycle Word Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It holds the program counter, a 32-entry general register file, a small instruction store, a small data store and all of the decode logic. Each instruction is fetched, decoded, executed and retired within one clock period. The register file and the data store are written on the rising edge at the end of that period.

The core executes five kinds of instruction: register-register arithmetic and logic, word load, word store, branch-if-equal and absolute jump. A loader fills the instruction store and the data store through hierarchical access while reset is held. After reset is released, the core runs from address 0. Several internal events are brought out as ports so that a testbench or system model can follow execution: the current PC, the fetched word, the register write-back and the data-store write.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0. While reset is high, no register write and no data-store write takes place, and the write-back and store strobes read 0.
- R2: Unless a jump or a taken branch applies, the PC advances by 4 on each clock. This includes a branch whose operands differ. Opcode bits are [31:26].
- R3: Opcode 000000 is the register-register class. The operands come from the registers indexed by [25:21] and [20:16], and the result goes to the register indexed by [15:11]. The function is selected by bits [5:0]: 100000 add, 100010 subtract, 100100 bitwise and, 100101 bitwise or, 101010 signed set-less-than, which yields 1 or 0.
- R4: Opcode 100011 loads the data word at address reg[25:21] + sext(bits[15:0]) into the register indexed by [20:16]. Address bits [1:0] are ignored.
- R5: Opcode 101011 stores reg[20:16] at address reg[25:21] + sext(bits[15:0]). A store never writes a register.
- R6: Opcode 000100 compares reg[25:21] with reg[20:16]. When they are equal, the next PC is PC+4 plus sext(bits[15:0]) shifted left by 2.
- R7: Opcode 000010 sets the next PC to the upper 4 bits of PC+4 followed by bits [25:0] and then 00. A jump writes neither a register nor the data store.
- R8: Register 0 always reads as zero. A write aimed at register 0 is still signalled on the write-back port but has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction now executing |
| instr_o | output | 32 | Instruction word fetched at pc_o |
| wb_en_o | output | 1 | A register write occurs at the coming edge |
| wb_addr_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value being written back |
| st_en_o | output | 1 | A data-store write occurs at the coming edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
The write-back and store ports are combinational functions of the instruction at pc_o and of the register state, so they are due in the same cycle the instruction is fetched. Their effect on registers and memory, and the new PC, become visible one rising edge later. The bench steps a behavioural model once per falling edge. At that point it first compares pc_o with the PC the model predicted at the previous step. It then compares the strobes and data of the current instruction before committing the model's own update. A reset raised just after an edge therefore takes effect on the next edge, and the model follows that edge-by-edge.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_sel_e;

  typedef struct packed {
    logic       dst_is_rd;   // write index from [15:11] instead of [20:16]
    logic       b_is_imm;    // second operand is the extended immediate
    logic       wb_from_mem; // write-back source is the data store
    logic       reg_we;
    logic       mem_re;
    logic       mem_we;
    logic       is_branch;
    logic       is_jump;
    logic [1:0] alu_class;   // 00 add, 01 sub, 10 by function field
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_sel_e sel,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (sel)
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [XLEN-1:0] imm);
    return pc4 + {imm[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [25:0] idx);
    return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode import sc_pkg::*; (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_sel_e   alu_sel
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        ctrl.alu_class = 2'b10;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
        ctrl.mem_re      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_class = 2'b01;
      end
      OPC_JUMP: begin
        ctrl.is_jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    case (ctrl.alu_class)
      2'b01:   alu_sel = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_SUB:  alu_sel = ALU_SUB;
          FN_AND:  alu_sel = ALU_AND;
          FN_OR:   alu_sel = ALU_OR;
          FN_SLT:  alu_sel = ALU_SLT;
          default: alu_sel = ALU_ADD;
        endcase
      end
      default: alu_sel = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic [$clog2(NREGS)-1:0] ra_a,
  input  logic [$clog2(NREGS)-1:0] ra_b,
  output logic [W-1:0]             rd_a,
  output logic [W-1:0]             rd_b,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [W-1:0]             wd
);

  localparam int AW = $clog2(NREGS);

  logic [W-1:0] regs [NREGS];
  logic [AW-1:0] ra [2];
  logic [W-1:0]  rd [2];

  assign ra[0] = ra_a;
  assign ra[1] = ra_b;

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rport
    assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end

  assign rd_a = rd[0];
  assign rd_b = rd[1];

endmodule

// File: rtl/sc_imem.sv
module sc_imem #(
  parameter int WORDS = 64,
  parameter int W     = 32
) (
  input  logic [$clog2(WORDS)-1:0] idx,
  output logic [W-1:0]             data
);

  logic [W-1:0] mem [WORDS];

  assign data = mem[idx];

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
  parameter int WORDS = 64,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic                     re,
  input  logic                     we,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = re ? mem[idx] : '0;

endmodule

// File: rtl/sc_core.sv
module sc_core import sc_pkg::*; #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        wb_en_o,
  output logic [4:0]  wb_addr_o,
  output logic [31:0] wb_data_o,
  output logic        st_en_o,
  output logic [31:0] st_addr_o,
  output logic [31:0] st_data_o
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, instr;
  logic [XLEN-1:0] rd1, rd2, imm_ext, alu_b, alu_res;
  logic [XLEN-1:0] mem_rdata, wb_data, br_tgt, j_tgt;
  logic [4:0]      rs_idx, rt_idx, rd_idx, wr_idx;
  ctrl_t           ctrl;
  alu_sel_e        alu_sel;
  logic            zero_flag, br_taken, wr_en, st_en;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  sc_imem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
    .idx  (pc_q[IAW+1:2]),
    .data (instr)
  );

  assign rs_idx  = instr[25:21];
  assign rt_idx  = instr[20:16];
  assign rd_idx  = instr[15:11];
  assign imm_ext = sext16(instr[15:0]);

  sc_decode u_dec (
    .opcode  (instr[31:26]),
    .funct   (instr[5:0]),
    .ctrl    (ctrl),
    .alu_sel (alu_sel)
  );

  assign wr_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;
  assign wr_en  = ctrl.reg_we & ~rst;
  assign st_en  = ctrl.mem_we & ~rst;

  sc_regfile #(.NREGS(32), .W(XLEN)) u_rf (
    .clk  (clk),
    .ra_a (rs_idx),
    .ra_b (rt_idx),
    .rd_a (rd1),
    .rd_b (rd2),
    .we   (wr_en),
    .wa   (wr_idx),
    .wd   (wb_data)
  );

  assign alu_b     = ctrl.b_is_imm ? imm_ext : rd2;
  assign alu_res   = alu_eval(alu_sel, rd1, alu_b);
  assign zero_flag = (alu_res == '0);

  sc_dmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk   (clk),
    .idx   (alu_res[DAW+1:2]),
    .re    (ctrl.mem_re),
    .we    (st_en),
    .wdata (rd2),
    .rdata (mem_rdata)
  );

  assign wb_data = ctrl.wb_from_mem ? mem_rdata : alu_res;

  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = branch_dest(pc_plus4, imm_ext);
  assign j_tgt    = jump_dest(pc_plus4, instr[25:0]);
  assign br_taken = ctrl.is_branch & zero_flag;

  always_comb begin
    if (ctrl.is_jump)   pc_next = j_tgt;
    else if (br_taken)  pc_next = br_tgt;
    else                pc_next = pc_plus4;
  end

  assign pc_o      = pc_q;
  assign instr_o   = instr;
  assign wb_en_o   = wr_en;
  assign wb_addr_o = wr_idx;
  assign wb_data_o = wb_data;
  assign st_en_o   = st_en;
  assign st_addr_o = alu_res;
  assign st_data_o = rd2;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val,
  input logic        zero_flag,
  input logic [29:0] imm_lo,
  input logic        wb_en,
  input logic        st_en
);

  logic [5:0] op;
  assign op = instr[31:26];

  AST_PC_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == 32'd0)); // R1

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (op != 6'b000100 && op != 6'b000010) |=> (pc == $past(pc) + 32'd4)); // R2

  AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000100 && !zero_flag) |=> (pc == $past(pc) + 32'd4)); // R2

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000100 && zero_flag) |=>
      (pc == $past(pc) + 32'd4 + {$past(imm_lo), 2'b00})); // R6

  AST_JUMP_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000010) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00})); // R7

  AST_JUMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000010) |-> (!wb_en && !st_en)); // R7

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !wb_en); // R5

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == 5'd0) |-> (rs_val == 32'd0)); // R8

endmodule

bind sc_core sc_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pc        (pc_q),
  .instr     (instr),
  .rs_idx    (rs_idx),
  .rs_val    (rd1),
  .zero_flag (zero_flag),
  .imm_lo    (imm_ext[29:0]),
  .wb_en     (wr_en),
  .st_en     (st_en)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o, instr_o, wb_data_o, st_addr_o, st_data_o;
  logic [4:0]  wb_addr_o;
  logic        wb_en_o, st_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr_o(instr_o),
    .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
    .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  // model state
  logic [31:0] prog [64];
  logic [31:0] mreg [32];
  logic [31:0] mdat [64];
  logic [31:0] m_pc = 32'd0;
  string       pc_req = "R1";
  bit          rst_at_edge = 1'b0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int word_idx);
    return {6'b000010, word_idx[25:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) rst_at_edge <= rst;

  always @(negedge clk) begin
    logic [31:0] ins, a, b, imm, res, npc, ea;
    logic [5:0]  op, fn;
    bit          ew, es;
    logic [4:0]  wa;
    string       req;
    if (rst_at_edge) begin
      chk(pc_o == 32'd0, "R1", "pc after reset", pc_o, 32'd0);
      m_pc = 32'd0;
    end else begin
      chk(pc_o == m_pc, pc_req, "pc", pc_o, m_pc);
    end
    if (rst) begin
      chk(!wb_en_o && !st_en_o, "R1", "strobes in reset", {30'd0, wb_en_o, st_en_o}, 32'd0);
    end else begin
      ins = prog[m_pc[7:2]];
      op = ins[31:26]; fn = ins[5:0];
      a = mreg[ins[25:21]]; b = mreg[ins[20:16]];
      imm = {{16{ins[15]}}, ins[15:0]};
      npc = m_pc + 32'd4; ew = 0; es = 0; wa = 5'd0; res = 32'd0; ea = a + imm;
      req = "R2";
      case (op)
        6'b000000: begin
          ew = 1; wa = ins[15:11]; req = "R3";
          case (fn)
            6'b100010: res = a - b;
            6'b100100: res = a & b;
            6'b100101: res = a | b;
            6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default:   res = a + b;
          endcase
        end
        6'b100011: begin ew = 1; wa = ins[20:16]; res = mdat[ea[7:2]]; req = "R4"; end
        6'b101011: begin es = 1; req = "R5"; end
        6'b000100: if (a == b) npc = m_pc + 32'd4 + (imm << 2);
        6'b000010: begin npc = {npc[31:28], ins[25:0], 2'b00}; req = "R7"; end
        default: ;
      endcase
      if (ew && wa == 5'd0) req = "R8";
      chk(wb_en_o == ew, req, "wb_en", {31'd0, wb_en_o}, {31'd0, ew});
      if (ew) begin
        chk(wb_addr_o == wa, req, "wb_addr", {27'd0, wb_addr_o}, {27'd0, wa});
        chk(wb_data_o == res, req, "wb_data", wb_data_o, res);
      end
      chk(st_en_o == es, req, "st_en", {31'd0, st_en_o}, {31'd0, es});
      if (es) begin
        chk(st_addr_o == ea, "R5", "st_addr", st_addr_o, ea);
        chk(st_data_o == b, ins[20:16] == 5'd0 ? "R8" : "R5", "st_data", st_data_o, b);
        mdat[ea[7:2]] = b;
      end
      if (ew && wa != 5'd0) mreg[wa] = res;
      pc_req = (op == 6'b000100) ? ((a == b) ? "R6" : "R2") : (op == 6'b000010 ? "R7" : "R2");
      m_pc = npc;
    end
  end

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin prog[i] = 32'd0; mdat[i] = 32'd0; end
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mdat[0] = 32'd5;
    mdat[1] = 32'hFFFF_FFF9;
    mdat[4] = 32'd32;
    prog[0]  = enc_i(6'b100011, 0, 1, 0);          // lw r1 <- 5
    prog[1]  = enc_i(6'b100011, 0, 2, 4);          // lw r2 <- -7
    prog[2]  = enc_r(1, 2, 3, 6'b100000);          // add
    prog[3]  = enc_r(1, 2, 4, 6'b100010);          // sub
    prog[4]  = enc_r(1, 2, 5, 6'b100100);          // and
    prog[5]  = enc_r(1, 2, 6, 6'b100101);          // or
    prog[6]  = enc_r(2, 1, 7, 6'b101010);          // slt -7<5 -> 1
    prog[7]  = enc_r(1, 2, 8, 6'b101010);          // slt 5<-7 -> 0
    prog[8]  = enc_r(1, 1, 0, 6'b100000);          // write to r0 ignored (R8)
    prog[9]  = enc_i(6'b101011, 0, 3, 8);          // sw r3
    prog[10] = enc_i(6'b101011, 0, 0, 12);         // sw r0 -> 0 (R8)
    prog[11] = enc_i(6'b000100, 1, 2, 5);          // beq not taken
    prog[12] = enc_i(6'b000100, 1, 1, 2);          // beq taken -> 15
    prog[13] = enc_r(1, 1, 9, 6'b100000);          // skipped
    prog[14] = enc_r(1, 1, 9, 6'b100000);          // skipped
    prog[15] = enc_i(6'b100011, 0, 10, 16);        // lw r10 <- 32
    prog[16] = enc_i(6'b101011, 10, 4, -4);        // sw negative offset
    prog[17] = enc_r(0, 1, 12, 6'b100000);         // r0 + r1
    prog[18] = enc_j(21);                          // jump
    prog[19] = enc_r(1, 1, 11, 6'b100000);         // skipped
    prog[20] = enc_r(1, 1, 11, 6'b100000);         // skipped
    prog[21] = enc_i(6'b000100, 0, 0, -1);         // backward branch to self
    for (int i = 0; i < 64; i++) begin
      dut_i.u_imem.mem[i] = prog[i];
      dut_i.u_dmem.mem[i] = mdat[i];
    end
    run_cycles(3);
    #1 rst = 1'b0;
    run_cycles(30);
    #1 rst = 1'b1;                                  // R1 mid-run reset
    run_cycles(2);
    #1 rst = 1'b0;
    run_cycles(30);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule